// File: doc/BRIEF.md
# Per-Port Source Address Tracker

This block watches the station address carried by every valid frame that a multiport repeater receives. Frame reception and address extraction happen upstream: they hand this block a one-cycle strobe, a port code and the 48-bit source address. Port codes 0 to 7 are the twisted-pair ports and code 8 is the single auxiliary port.

For each port the block keeps the last source address it saw and counts how often that address changes. Software can preload the stored address. This lets it pin down the expected station and detect a stranger as a change.

One global address register is also compared with every incoming source address. This maps a chosen node to the port it is attached to. Both events set status bits that clear when read. The status bits are masked by per-port enables, a class enable per event type and a global enable, and together they drive one shared active-low interrupt. The host uses a byte-wide register port for status, enables and configuration. It uses wide side ports for address preload, match programming and counter observation.

Top module: `sa_tracker`

## Requirements
- R1: A frame strobe on port code p (0..8) whose address differs from port p's stored address replaces the stored address and adds one to port p's change counter, which wraps modulo 2^CNT_W.
- R2: A frame whose address equals the stored one leaves the stored address, the counter and the change status untouched.
- R3: A change on port p sets change status: select 0 returns twisted-pair bits with bit p for port p, and select 1 returns the auxiliary port in bit 7 with bits 6..0 reading 0.
- R4: A preload (sa_wr_en) replaces a port's stored address, so a later frame from another address counts as a change. A preload and a frame on the same port in the same cycle store the preload value, while the frame is still judged against the old value.
- R5: A frame whose address equals the match register (written through match_wr_en) sets the receiving port's match status: select 2 holds twisted-pair bits 7..0 and select 3 holds the auxiliary port in bit 7.
- R6: A read strobe on select 0, 1, 2 or 3 clears the bits that select shows, at that clock edge. The read data is the value before clearing. A set arriving in the same cycle as the clear wins.
- R7: Reset clears all status, all enables and the configuration, but keeps the stored addresses, the counters and the match register.
- R8: irq_n is 0 exactly when config bit 0 (global) is 1 and either config bit 1 is 1 with any change bit enabled, or config bit 2 is 1 with any match bit enabled. Config is select 8. Change enables are at select 4 (ports 7..0) and select 5 (bit 7 = auxiliary). Match enables are at select 6 and select 7 in the same layout.
- R9: Clearing the global enable or a per-port enable releases irq_n without clearing the status bits.
- R10: Select 9 returns bit 7 = interrupt active and bit 6 = any match status set. Bit 6 therefore stays 1 until both match status registers have been read.
- R11: Frame strobes with a port code of 9 to 15 change no address, counter or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe for a received valid frame |
| frm_port | input | 4 | Receiving port code (0..7 twisted pair, 8 auxiliary) |
| frm_sa | input | SA_W (48) | Source address of the frame |
| sa_wr_en | input | 1 | Preload strobe for a stored address |
| sa_wr_port | input | 4 | Port whose stored address is preloaded |
| sa_wr_data | input | SA_W (48) | Preload value |
| match_wr_en | input | 1 | Write strobe for the match register |
| match_wr_data | input | SA_W (48) | Match register value |
| reg_sel | input | 4 | Byte register select |
| reg_rd | input | 1 | Read strobe (clears status at the edge) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| mon_port | input | 4 | Port whose address and counter are shown |
| mon_sa | output | SA_W (48) | Stored address of mon_port |
| mon_cnt | output | CNT_W (32) | Change counter of mon_port |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
A status bit can be set by a frame and cleared by a host read in the same cycle. The bench provokes this by driving a changed-address frame on one port while a read strobe on the same status select is high. Other bits in that select are already set. The bench checks that the read returns the old byte and that, after the edge, only the newly set bit remains. It also overlaps a preload with a frame on the same port and checks the stored value, the counter step and the status bit.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int TP_PORTS = 8;
    localparam int NPORTS   = TP_PORTS + 1;
    localparam int AUX_IDX  = TP_PORTS;
    localparam int PORT_W   = 4;

    localparam logic [3:0] SEL_CHG_TP  = 4'd0;
    localparam logic [3:0] SEL_CHG_AUX = 4'd1;
    localparam logic [3:0] SEL_MAT_TP  = 4'd2;
    localparam logic [3:0] SEL_MAT_AUX = 4'd3;
    localparam logic [3:0] SEL_CEN_TP  = 4'd4;
    localparam logic [3:0] SEL_CEN_AUX = 4'd5;
    localparam logic [3:0] SEL_MEN_TP  = 4'd6;
    localparam logic [3:0] SEL_MEN_AUX = 4'd7;
    localparam logic [3:0] SEL_CFG     = 4'd8;
    localparam logic [3:0] SEL_SUMMARY = 4'd9;

    typedef struct packed {
        logic match_cls;
        logic chg_cls;
        logic gie;
    } cfg_t;
endpackage

// File: rtl/sat_slot.sv
module sat_slot #(
    parameter int SA_W  = 48,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             frm_hit,
    input  logic [SA_W-1:0]  frm_sa,
    input  logic             pre_wr,
    input  logic [SA_W-1:0]  pre_data,
    output logic [SA_W-1:0]  sa_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             changed
);
    typedef struct packed {
        logic [SA_W-1:0]  sa;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t st_q, st_d;

    always_comb begin
        changed = frm_hit && (frm_sa != st_q.sa);
        st_d    = st_q;
        if (changed) begin
            st_d.sa  = frm_sa;
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (pre_wr) begin
            st_d.sa = pre_data;
        end
    end

    // address and counter deliberately survive reset
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sa_q  = st_q.sa;
    assign cnt_q = st_q.cnt;
endmodule

// File: rtl/sat_flags.sv
module sat_flags #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_tp,
    input  logic         clr_aux,
    input  logic         en_wr_tp,
    input  logic         en_wr_aux,
    input  logic [7:0]   wdata,
    output logic [N-1:0] st_q,
    output logic [N-1:0] en_q,
    output logic         pend
);
    localparam int TP = N - 1;

    typedef struct packed {
        logic [N-1:0] st;
        logic [N-1:0] en;
    } flags_t;

    flags_t r_q, r_d;
    logic [N-1:0] clr_mask;

    always_comb begin
        clr_mask     = '0;
        clr_mask[TP] = clr_aux;
        for (int i = 0; i < TP; i++) begin
            clr_mask[i] = clr_tp;
        end
        r_d    = r_q;
        // a set in the clearing cycle survives
        r_d.st = (r_q.st & ~clr_mask) | set_vec;
        if (en_wr_tp) begin
            r_d.en[TP-1:0] = wdata[TP-1:0];
        end
        if (en_wr_aux) begin
            r_d.en[TP] = wdata[7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q = r_q.st;
    assign en_q = r_q.en;
    assign pend = |(r_q.st & r_q.en);
endmodule

// File: rtl/sa_tracker.sv
module sa_tracker
    import sat_pkg::*;
#(
    parameter int SA_W  = 48,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  logic [3:0]       frm_port,
    input  logic [SA_W-1:0]  frm_sa,
    input  logic             sa_wr_en,
    input  logic [3:0]       sa_wr_port,
    input  logic [SA_W-1:0]  sa_wr_data,
    input  logic             match_wr_en,
    input  logic [SA_W-1:0]  match_wr_data,
    input  logic [3:0]       reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [3:0]       mon_port,
    output logic [SA_W-1:0]  mon_sa,
    output logic [CNT_W-1:0] mon_cnt,
    output logic             irq_n
);
    logic [SA_W-1:0]  slot_sa  [NPORTS];
    logic [CNT_W-1:0] slot_cnt [NPORTS];
    logic [NPORTS-1:0] frm_hit, chg_set, match_set;
    logic [NPORTS-1:0] chg_st, chg_en, match_st, match_en;
    logic chg_pend, match_pend;
    logic sa_equal;

    logic [SA_W-1:0] match_q, match_d;
    cfg_t cfg_q, cfg_d;
    logic cfg_gie;
    logic irq_act;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[7:3];
    assign sa_equal     = (frm_sa == match_q);

    for (genvar i = 0; i < NPORTS; i++) begin : g_slot
        assign frm_hit[i]   = frm_valid && (frm_port == PORT_W'(i));
        assign match_set[i] = frm_hit[i] && sa_equal;
        sat_slot #(.SA_W(SA_W), .CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .frm_hit  (frm_hit[i]),
            .frm_sa   (frm_sa),
            .pre_wr   (sa_wr_en && (sa_wr_port == PORT_W'(i))),
            .pre_data (sa_wr_data),
            .sa_q     (slot_sa[i]),
            .cnt_q    (slot_cnt[i]),
            .changed  (chg_set[i])
        );
    end

    sat_flags #(.N(NPORTS)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (chg_set),
        .clr_tp    (reg_rd && reg_sel == SEL_CHG_TP),
        .clr_aux   (reg_rd && reg_sel == SEL_CHG_AUX),
        .en_wr_tp  (reg_wr && reg_sel == SEL_CEN_TP),
        .en_wr_aux (reg_wr && reg_sel == SEL_CEN_AUX),
        .wdata     (reg_wdata),
        .st_q      (chg_st),
        .en_q      (chg_en),
        .pend      (chg_pend)
    );

    sat_flags #(.N(NPORTS)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (match_set),
        .clr_tp    (reg_rd && reg_sel == SEL_MAT_TP),
        .clr_aux   (reg_rd && reg_sel == SEL_MAT_AUX),
        .en_wr_tp  (reg_wr && reg_sel == SEL_MEN_TP),
        .en_wr_aux (reg_wr && reg_sel == SEL_MEN_AUX),
        .wdata     (reg_wdata),
        .st_q      (match_st),
        .en_q      (match_en),
        .pend      (match_pend)
    );

    always_comb begin
        match_d = match_wr_en ? match_wr_data : match_q;
        cfg_d   = cfg_q;
        if (reg_wr && reg_sel == SEL_CFG) begin
            cfg_d = cfg_t'(reg_wdata[2:0]);
        end
    end

    always_ff @(posedge clk) begin
        match_q <= match_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_gie = cfg_q.gie;
    assign irq_act = cfg_q.gie && ((cfg_q.chg_cls && chg_pend) ||
                                   (cfg_q.match_cls && match_pend));
    assign irq_n   = !irq_act;

    always_comb begin
        case (reg_sel)
            SEL_CHG_TP:  reg_rdata = chg_st[TP_PORTS-1:0];
            SEL_CHG_AUX: reg_rdata = {chg_st[AUX_IDX], 7'b0};
            SEL_MAT_TP:  reg_rdata = match_st[TP_PORTS-1:0];
            SEL_MAT_AUX: reg_rdata = {match_st[AUX_IDX], 7'b0};
            SEL_CEN_TP:  reg_rdata = chg_en[TP_PORTS-1:0];
            SEL_CEN_AUX: reg_rdata = {chg_en[AUX_IDX], 7'b0};
            SEL_MEN_TP:  reg_rdata = match_en[TP_PORTS-1:0];
            SEL_MEN_AUX: reg_rdata = {match_en[AUX_IDX], 7'b0};
            SEL_CFG:     reg_rdata = {5'b0, cfg_q};
            SEL_SUMMARY: reg_rdata = {irq_act, |match_st, 6'b0};
            default:     reg_rdata = 8'h00;
        endcase
    end

    always_comb begin
        if (mon_port < PORT_W'(NPORTS)) begin
            mon_sa  = slot_sa[mon_port];
            mon_cnt = slot_cnt[mon_port];
        end else begin
            mon_sa  = '0;
            mon_cnt = '0;
        end
    end
endmodule

// File: rtl/sat_checker.sv
module sat_checker
    import sat_pkg::*;
#(
    parameter int SA_W  = 48,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic [3:0]       frm_port,
    input logic [SA_W-1:0]  frm_sa,
    input logic             sa_wr_en,
    input logic [3:0]       sa_wr_port,
    input logic [3:0]       reg_sel,
    input logic             reg_rd,
    input logic             irq_n,
    input logic [SA_W-1:0]  slot_sa  [NPORTS],
    input logic [CNT_W-1:0] slot_cnt [NPORTS],
    input logic [NPORTS-1:0] chg_st,
    input logic [NPORTS-1:0] match_st,
    input logic [SA_W-1:0]  match_q,
    input logic             cfg_gie
);
    logic frm_ok;
    assign frm_ok = frm_valid && (frm_port < PORT_W'(NPORTS));

    // R1: a differing address is stored one cycle later
    a_r1_sa_update: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok && frm_sa != slot_sa[frm_port] &&
        !(sa_wr_en && sa_wr_port == frm_port)
        |=> slot_sa[$past(frm_port)] == $past(frm_sa));

    // R1: the counter steps by exactly one on a change
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok && frm_sa != slot_sa[frm_port]
        |=> slot_cnt[$past(frm_port)] == CNT_W'($past(slot_cnt[frm_port]) + 1));

    // R2: a repeated address leaves the counter alone
    a_r2_same_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok && frm_sa == slot_sa[frm_port]
        |=> slot_cnt[$past(frm_port)] == $past(slot_cnt[frm_port]));

    // R5: a matching address sets the receiving port's match bit
    a_r5_match_set: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ok && frm_sa == match_q |=> match_st[$past(frm_port)]);

    // R6: a twisted-pair change read with no frame empties those bits
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_sel == SEL_CHG_TP && !frm_valid
        |=> chg_st[TP_PORTS-1:0] == '0);

    // R9: with the global enable off the interrupt is released
    a_r9_gie_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_gie |-> irq_n);
endmodule

bind sa_tracker sat_checker #(.SA_W(SA_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .frm_port   (frm_port),
    .frm_sa     (frm_sa),
    .sa_wr_en   (sa_wr_en),
    .sa_wr_port (sa_wr_port),
    .reg_sel    (reg_sel),
    .reg_rd     (reg_rd),
    .irq_n      (irq_n),
    .slot_sa    (slot_sa),
    .slot_cnt   (slot_cnt),
    .chg_st     (chg_st),
    .match_st   (match_st),
    .match_q    (match_q),
    .cfg_gie    (cfg_gie)
);

// File: tb/sa_tracker_test.sv
module sa_tracker_test;
    localparam int SA_W  = 48;
    localparam int CNT_W = 4;
    localparam int NP    = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0;
    logic [3:0] frm_port = '0;
    logic [SA_W-1:0] frm_sa = '0;
    logic sa_wr_en = 1'b0;
    logic [3:0] sa_wr_port = '0;
    logic [SA_W-1:0] sa_wr_data = '0;
    logic match_wr_en = 1'b0;
    logic [SA_W-1:0] match_wr_data = '0;
    logic [3:0] reg_sel = '0;
    logic reg_rd = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] mon_port = '0;
    logic [SA_W-1:0] mon_sa;
    logic [CNT_W-1:0] mon_cnt;
    logic irq_n;

    int checks = 0;
    int failures = 0;

    logic [SA_W-1:0] exp_sa  [NP];
    int              exp_cnt [NP];
    logic [NP-1:0]   exp_chg;
    logic [NP-1:0]   exp_mat;
    logic [SA_W-1:0] exp_match;

    always #5 clk = ~clk;

    sa_tracker #(.SA_W(SA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_port(frm_port),
        .frm_sa(frm_sa), .sa_wr_en(sa_wr_en), .sa_wr_port(sa_wr_port),
        .sa_wr_data(sa_wr_data), .match_wr_en(match_wr_en),
        .match_wr_data(match_wr_data), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mon_port(mon_port), .mon_sa(mon_sa), .mon_cnt(mon_cnt), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bench model of one frame
    task automatic model_frame(input int p, input logic [SA_W-1:0] sa);
        if (p < NP) begin
            if (sa != exp_sa[p]) begin
                exp_sa[p]  = sa;
                exp_cnt[p] = (exp_cnt[p] + 1) % 16;
                exp_chg[p] = 1'b1;
            end
            if (sa == exp_match) exp_mat[p] = 1'b1;
        end
    endtask

    task automatic frame(input int p, input logic [SA_W-1:0] sa);
        @(negedge clk);
        frm_valid = 1'b1; frm_port = p[3:0]; frm_sa = sa;
        @(negedge clk);
        frm_valid = 1'b0;
        model_frame(p, sa);
    endtask

    task automatic preload(input int p, input logic [SA_W-1:0] sa);
        @(negedge clk);
        sa_wr_en = 1'b1; sa_wr_port = p[3:0]; sa_wr_data = sa;
        @(negedge clk);
        sa_wr_en = 1'b0;
        exp_sa[p] = sa;
    endtask

    task automatic set_match(input logic [SA_W-1:0] sa);
        @(negedge clk);
        match_wr_en = 1'b1; match_wr_data = sa;
        @(negedge clk);
        match_wr_en = 1'b0;
        exp_match = sa;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        if (sel == 4'd0) exp_chg[7:0] = '0;
        if (sel == 4'd1) exp_chg[8]   = 1'b0;
        if (sel == 4'd2) exp_mat[7:0] = '0;
        if (sel == 4'd3) exp_mat[8]   = 1'b0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_slot(input string tag, input int p);
        mon_port = p[3:0];
        #1;
        check(tag, 64'(mon_sa), 64'(exp_sa[p]));
        check(tag, 64'(mon_cnt), 64'(exp_cnt[p]));
    endtask

    task automatic clear_all();
        logic [7:0] d;
        rd(4'd0, d); rd(4'd1, d); rd(4'd2, d); rd(4'd3, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [SA_W-1:0] base;
        exp_chg = '0; exp_mat = '0; exp_match = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: status, enables and config at zero after reset
        for (int s = 0; s < 10; s++) begin
            rd(s[3:0], d);
            check("R7 reset register value", 64'(d), 64'h0);
        end
        check("R7 irq_n idle after reset", 64'(irq_n), 64'h1);

        // preload every port, match register far away; read counter baselines
        set_match(48'hFFFF_0000_0000);
        for (int p = 0; p < NP; p++) begin
            preload(p, 48'h0200_0000_0000 | 48'(p));
            mon_port = p[3:0];
            #1 exp_cnt[p] = int'(mon_cnt);
            check_slot("R4 preload stored", p);
        end
        clear_all();

        // R1 R2 sweep: new, repeat, new, repeat on every port
        for (int p = 0; p < NP; p++) begin
            base = 48'h0A00_0000_0000 | (48'(p) << 8);
            frame(p, base | 48'h1);
            check_slot("R1 change stored and counted", p);
            frame(p, base | 48'h1);
            check_slot("R2 repeat not counted", p);
            frame(p, base | 48'h2);
            check_slot("R1 second change", p);
            frame(p, base | 48'h2);
            check_slot("R2 second repeat", p);
        end
        // R3 status layout
        rd(4'd0, d);
        check("R3 tp change byte", 64'(d), 64'hFF);
        rd(4'd1, d);
        check("R3 aux change byte", 64'(d), 64'h80);
        rd(4'd0, d);
        check("R6 tp change cleared by read", 64'(d), 64'h00);
        rd(4'd1, d);
        check("R6 aux change cleared by read", 64'(d), 64'h00);

        // R2 repeated address sets no change status
        frame(4, exp_sa[4]);
        rd(4'd0, d);
        check("R2 repeat leaves status clear", 64'(d), 64'h00);

        // R4 preload then frame from another station counts; preloaded one does not
        preload(6, 48'h0B00_0000_0066);
        frame(6, 48'h0B00_0000_0066);
        check_slot("R4 preloaded address not a change", 6);
        frame(6, 48'h0C00_0000_0066);
        check_slot("R4 stranger after preload counted", 6);
        rd(4'd0, d);
        check("R4 stranger sets status", 64'(d), 64'h40);

        // R4 preload and frame on one port in one cycle
        @(negedge clk);
        sa_wr_en = 1'b1; sa_wr_port = 4'd2; sa_wr_data = 48'h0D00_0000_0002;
        frm_valid = 1'b1; frm_port = 4'd2; frm_sa = 48'h0E00_0000_0002;
        @(negedge clk);
        sa_wr_en = 1'b0; frm_valid = 1'b0;
        exp_cnt[2] = (exp_cnt[2] + 1) % 16;
        exp_sa[2]  = 48'h0D00_0000_0002;
        check_slot("R4 overlap: preload stored, frame counted", 2);
        rd(4'd0, d);
        check("R4 overlap sets status", 64'(d), 64'h04);

        // R1 wrap: 16 changes return counter to start
        for (int k = 0; k < 16; k++) begin
            frame(5, 48'h0F00_0000_0000 | 48'(k + 1));
        end
        check_slot("R1 counter wraps", 5);
        clear_all();

        // R6 set and read-clear in same cycle
        frame(5, 48'h1100_0000_0005);
        @(negedge clk);
        frm_valid = 1'b1; frm_port = 4'd3; frm_sa = 48'h1100_0000_0003;
        reg_sel = 4'd0; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        frm_valid = 1'b0; reg_rd = 1'b0;
        model_frame(3, 48'h1100_0000_0003);
        check("R6 read returns pre-clear byte", 64'(d), 64'h20);
        rd(4'd0, d);
        check("R6 set wins over same-cycle clear", 64'(d), 64'h08);

        // R11 ignored port codes
        for (int p = 9; p < 16; p++) begin
            frame(p, 48'h2200_0000_0000 | 48'(p));
        end
        set_match(48'h2200_0000_0009);
        frame(9, 48'h2200_0000_0009);
        for (int p = 0; p < NP; p++) check_slot("R11 ignored codes leave slots", p);
        rd(4'd0, d); check("R11 no tp change", 64'(d), 64'h0);
        rd(4'd1, d); check("R11 no aux change", 64'(d), 64'h0);
        rd(4'd2, d); check("R11 no tp match", 64'(d), 64'h0);

        // R5 match on each port
        set_match(48'h3300_0000_0033);
        for (int p = 0; p < NP; p++) begin
            frame(p, 48'h3300_0000_0033);
        end
        rd(4'd9, d);
        check("R10 summary match flag", 64'(d), 64'h40);
        rd(4'd2, d);
        check("R5 tp match byte", 64'(d), 64'hFF);
        rd(4'd9, d);
        check("R10 flag held until aux read", 64'(d), 64'h40);
        rd(4'd3, d);
        check("R5 aux match byte", 64'(d), 64'h80);
        rd(4'd9, d);
        check("R10 flag cleared after both reads", 64'(d), 64'h00);
        clear_all();

        // R8 R9 interrupt masking
        wr(4'd4, 8'hFF);
        frame(1, 48'h4400_0000_0001);
        check("R8 no irq with global off", 64'(irq_n), 64'h1);
        wr(4'd8, 8'h03);
        check("R8 irq on change class", 64'(irq_n), 64'h0);
        rd(4'd8, d);
        check("R8 config readback", 64'(d), 64'h03);
        wr(4'd4, 8'hFD);
        check("R9 per-port disable releases irq", 64'(irq_n), 64'h1);
        wr(4'd4, 8'hFF);
        check("R8 irq back on re-enable", 64'(irq_n), 64'h0);
        wr(4'd8, 8'h02);
        check("R9 global off releases irq", 64'(irq_n), 64'h1);
        rd(4'd0, d);
        check("R9 status kept while masked", 64'(d), 64'h02);
        wr(4'd8, 8'h03);
        check("R8 no irq after clear", 64'(irq_n), 64'h1);
        wr(4'd8, 8'h05);
        wr(4'd7, 8'h80);
        frame(8, 48'h3300_0000_0033);
        check("R8 irq on aux match class", 64'(irq_n), 64'h0);
        rd(4'd9, d);
        check("R10 summary irq and match", 64'(d), 64'hC0);
        wr(4'd8, 8'h03);
        check("R8 match class off releases irq", 64'(irq_n), 64'h1);

        // R7 reset keeps addresses and counters, clears the rest
        frame(7, 48'h5500_0000_0007);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_chg = '0; exp_mat = '0;
        for (int s = 0; s < 10; s++) begin
            rd(s[3:0], d);
            check("R7 register cleared by reset", 64'(d), 64'h0);
        end
        for (int p = 0; p < NP; p++) check_slot("R7 slot survives reset", p);
        frame(0, 48'h3300_0000_0033);
        rd(4'd2, d);
        check("R7 match register survives reset", 64'(d), 64'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule